// File: doc/BRIEF.md
# Soft Reset and Clock Gate Controller

This block holds the two control bits that put a peripheral into reset and stop its clock. Software reaches them through one 32-bit register that appears at four addresses: a plain write, a bit-set alias, a bit-clear alias and a bit-invert alias. Reads return the live state of both bits whatever the address. The reset bit drives the peripheral's internal reset directly, and the gate bit drives a clock-enable that the peripheral's clock gate consumes.

When software raises the reset bit while the clock is still running, the controller raises the gate bit on its own a fixed number of cycles later. This lets the reset reach the peripheral before its clock stops. Software polls for the gate bit, clears the reset bit and polls it back to 0, waits, then clears the gate bit and polls until it reads 0. After a power-on reset both bits read 1, so the peripheral starts in reset with its clock stopped.

Top module: `srcg_ctrl`

## Requirements
- R1: In the cycle after the synchronous reset input is released, read data is 0xC000_0000: the reset bit (bit 31) and the gate bit (bit 30) both read 1.
- R2: A write to byte offset 0x0 loads bit 31 and bit 30 from the written data.
- R3: A write to offset 0x4 sets each of the two bits for which the written data holds a 1 and leaves the other bit unchanged.
- R4: A write to offset 0x8 clears each of the two bits for which the written data holds a 1 and leaves the other bit unchanged.
- R5: A write to offset 0xC inverts each of the two bits for which the written data holds a 1 and leaves the other bit unchanged.
- R6: Bits 29 to 0 always read 0 and writes to them have no effect. Address bits 1 and 0 are ignored, and reads return the state at any address.
- R7: While the reset bit reads 1 and the gate bit reads 0, the gate bit becomes 1 without a write exactly GATE_DELAY clock edges after the edge that made this combination. If the gate is cleared again while reset stays 1, the count restarts.
- R8: When a write lands on the edge where the automatic gate assertion of R7 falls due, the gate bit ends 1 even if the write would clear it. The reset bit still takes the value the write gives it.
- R9: The peripheral reset output equals the reset bit and the clock-enable output equals the inverted gate bit, in the same cycle that read data shows them.
- R10: While the reset bit is 0, the gate bit changes only through a write.
- R11: The reset bit changes only through a write or the block's own reset.

Ports:

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Write strobe, one write per cycle it is high |
| addr_i | input | 4 | Byte offset: 0x0 plain, 0x4 set, 0x8 clear, 0xC invert |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Live register state |
| periph_rst_o | output | 1 | Reset to the protected peripheral, high while the reset bit is 1 |
| periph_clk_en_o | output | 1 | Clock enable to the peripheral's clock gate, low while the gate bit is 1 |

## Verification
The software write path and the automatic gate assertion can both act on the gate bit in the same cycle. The bench provokes this by raising the reset bit with the gate at 0, idling GATE_DELAY-1 cycles, and then issuing a clear-alias write of the gate bit, and also a clear of the reset bit, on the edge where the assertion falls due. The gate bit must read 1 afterwards while the reset bit follows the write. Random writes then keep reaching the gate window at arbitrary offsets, and a bench reference model predicts every cycle's read data.

// File: rtl/srcg_pkg.sv
package srcg_pkg;

    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 4;
    localparam int SRST_BIT = 31;
    localparam int GATE_BIT = 30;

    // Alias selected by address bits [3:2]
    typedef enum logic [1:0] {
        OP_LOAD = 2'd0,
        OP_SET  = 2'd1,
        OP_CLR  = 2'd2,
        OP_INV  = 2'd3
    } alias_op_e;

    typedef struct packed {
        logic srst;
        logic gate;
    } ctl_bits_t;

    function automatic ctl_bits_t alias_apply(alias_op_e op, ctl_bits_t cur, ctl_bits_t wv);
        ctl_bits_t r;
        case (op)
            OP_LOAD: r = wv;
            OP_SET: begin
                r.srst = cur.srst | wv.srst;
                r.gate = cur.gate | wv.gate;
            end
            OP_CLR: begin
                r.srst = cur.srst & ~wv.srst;
                r.gate = cur.gate & ~wv.gate;
            end
            default: begin
                r.srst = cur.srst ^ wv.srst;
                r.gate = cur.gate ^ wv.gate;
            end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/srcg_alias_dec.sv
module srcg_alias_dec
    import srcg_pkg::*;
(
    input  logic      wr_en_i,
    input  alias_op_e op_i,
    input  ctl_bits_t wval_i,
    input  ctl_bits_t cur_i,
    output ctl_bits_t nxt_o
);

    always_comb begin
        if (wr_en_i) begin
            nxt_o = alias_apply(op_i, cur_i, wval_i);
        end else begin
            nxt_o = cur_i;
        end
    end

endmodule

// File: rtl/srcg_gate_seq.sv
module srcg_gate_seq
    import srcg_pkg::*;
#(
    parameter int GATE_DELAY = 4
) (
    input  logic      clk_i,
    input  logic      rst_i,
    input  ctl_bits_t cur_i,
    output logic      fire_o
);

    localparam int CNT_W = (GATE_DELAY > 1) ? $clog2(GATE_DELAY) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(GATE_DELAY - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             armed;

    assign armed  = cur_i.srst & ~cur_i.gate;
    assign fire_o = armed & (cnt_q == LAST);

    always_ff @(posedge clk_i) begin
        if (rst_i || !armed || fire_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R7
    no_cnt_overrun_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        cnt_q <= LAST);

    // R7
    cnt_idle_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !armed |=> cnt_q == '0);

endmodule

// File: rtl/srcg_ctrl.sv
module srcg_ctrl
    import srcg_pkg::*;
#(
    parameter int GATE_DELAY = 4
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              periph_rst_o,
    output logic              periph_clk_en_o
);

    ctl_bits_t cur_q;
    ctl_bits_t wval;
    ctl_bits_t wnxt;
    alias_op_e op;
    logic      fire;
    logic      unused_inputs;

    assign op        = alias_op_e'(addr_i[3:2]);
    assign wval.srst = wdata_i[SRST_BIT];
    assign wval.gate = wdata_i[GATE_BIT];
    assign unused_inputs = ^{addr_i[1:0], wdata_i[29:0]};

    srcg_alias_dec u_dec (
        .wr_en_i (wr_en_i),
        .op_i    (op),
        .wval_i  (wval),
        .cur_i   (cur_q),
        .nxt_o   (wnxt)
    );

    srcg_gate_seq #(.GATE_DELAY(GATE_DELAY)) u_seq (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .cur_i  (cur_q),
        .fire_o (fire)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cur_q.srst <= 1'b1;
            cur_q.gate <= 1'b1;
        end else begin
            cur_q.srst <= wnxt.srst;
            cur_q.gate <= wnxt.gate | fire;
        end
    end

    always_comb begin
        rdata_o           = '0;
        rdata_o[SRST_BIT] = cur_q.srst;
        rdata_o[GATE_BIT] = cur_q.gate;
    end

    assign periph_rst_o    = cur_q.srst;
    assign periph_clk_en_o = ~cur_q.gate;

    // R1
    reset_state_chk: assert property (@(posedge clk_i)
        rst_i |=> (periph_rst_o && !periph_clk_en_o));

    // R7
    auto_gate_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        fire |=> !periph_clk_en_o);

    // R8
    collide_srst_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (fire && wr_en_i && op == OP_CLR && wval.srst) |=> !periph_rst_o);

    // R3
    set_srst_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_en_i && op == OP_SET && wval.srst) |=> periph_rst_o);

    // R4
    clr_gate_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_en_i && op == OP_CLR && wval.gate && !fire) |=> periph_clk_en_o);

    // R11
    srst_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !wr_en_i |=> $stable(periph_rst_o));

    // R10
    gate_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (!wr_en_i && !periph_rst_o) |=> $stable(periph_clk_en_o));

endmodule

// File: tb/srcg_ctrl_bench.sv
module srcg_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DLY        = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        we  = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        prst;
    logic        pclk_en;

    int checks = 0;
    int errors = 0;

    // reference state
    bit m_srst, m_gate;
    int m_cnt;

    always #(CLK_PERIOD/2) clk = ~clk;

    srcg_ctrl #(.GATE_DELAY(DLY)) u_srcg_ctrl (
        .clk_i           (clk),
        .rst_i           (rst),
        .wr_en_i         (we),
        .addr_i          (addr),
        .wdata_i         (wdata),
        .rdata_o         (rdata),
        .periph_rst_o    (prst),
        .periph_clk_en_o (pclk_en)
    );

    function automatic logic [31:0] exp_rdata(bit s, bit g);
        return {s, g, 30'd0};
    endfunction

    // one bit under an alias: 0 load, 1 set, 2 clear, 3 invert
    function automatic bit alias_bit(int op, bit cur, bit w);
        case (op)
            0: return w;
            1: return cur | w;
            2: return cur & ~w;
            default: return cur ^ w;
        endcase
    endfunction

    task automatic check(string tag);
        logic [31:0] e;
        e = exp_rdata(m_srst, m_gate);
        checks++;
        if (rdata !== e || prst !== m_srst || pclk_en !== !m_gate) begin
            errors++;
            $display("FAIL %s: rdata=%h rst=%b clk_en=%b expected rdata=%h rst=%b clk_en=%b",
                     tag, rdata, prst, pclk_en, e, m_srst, !m_gate);
        end
    endtask

    // called at a negedge: apply inputs, cross one posedge, check at next negedge
    task automatic step(bit w, logic [3:0] a, logic [31:0] d, string tag);
        bit fire, ns, ng;
        we = w; addr = a; wdata = d;
        fire = m_srst && !m_gate && (m_cnt == DLY - 1);
        ns = w ? alias_bit(int'(a[3:2]), m_srst, d[31]) : m_srst;
        ng = w ? alias_bit(int'(a[3:2]), m_gate, d[30]) : m_gate;
        ng = ng | fire;
        m_cnt = (m_srst && !m_gate && !fire) ? m_cnt + 1 : 0;
        @(posedge clk);
        @(negedge clk);
        m_srst = ns;
        m_gate = ng;
        we = 1'b0;
        check(tag);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_srst = 1; m_gate = 1; m_cnt = 0;
        check("R1 reset state");

        // R6: unused bits ignored, low address bits ignored
        step(1, 4'h3, 32'hFFFF_FFFF, "R6 all-ones load");
        // R2 / R9
        step(1, 4'h0, 32'h0000_0000, "R2 load zero");
        check("R9 outputs running");
        // R10: no spontaneous gate change
        for (int i = 0; i < 8; i++) step(0, 4'h0, 32'h0, "R10 idle");
        // R3 / R4
        step(1, 4'h4, 32'h4000_0000, "R3 set gate only");
        step(1, 4'h8, 32'h4000_0000, "R4 clear gate");
        // R7: timing of the automatic gate
        step(1, 4'h0, 32'h8000_0000, "R2 load reset only");
        for (int i = 0; i < DLY - 1; i++) step(0, 4'h0, 32'h0, "R7 before gate");
        step(0, 4'h0, 32'h0, "R7 gate asserted");
        // release order
        step(1, 4'h8, 32'h8000_0000, "R4 clear reset");
        for (int i = 0; i < 4; i++) step(0, 4'h0, 32'h0, "R11 reset stays low");
        step(1, 4'h8, 32'h4000_0000, "R4 clear gate after release");
        // R5 invert
        step(1, 4'hC, 32'hC000_0000, "R5 invert both");
        step(1, 4'hC, 32'h4000_0000, "R5 invert gate");
        for (int i = 0; i < DLY; i++) step(0, 4'h0, 32'h0, "R7 restart after clear");
        // R8: clear gate on the due edge
        step(1, 4'h0, 32'h8000_0000, "R2 arm collision");
        for (int i = 0; i < DLY - 1; i++) step(0, 4'h0, 32'h0, "R7 window");
        step(1, 4'h8, 32'h4000_0000, "R8 clear gate vs auto");
        // R8: clear reset on the due edge
        step(1, 4'h0, 32'h8000_0000, "R2 arm collision 2");
        for (int i = 0; i < DLY - 1; i++) step(0, 4'h0, 32'h0, "R7 window 2");
        step(1, 4'h8, 32'hC000_0000, "R8 clear both vs auto");
        // random mix
        for (int i = 0; i < 400; i++) begin
            bit          w;
            logic [3:0]  a;
            logic [31:0] d;
            w = ($urandom % 3) != 0;
            a = 4'($urandom);
            d = $urandom;
            step(w, a, d, "R2/R3/R4/R5/R7/R8 random");
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule